// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is a single down-counting channel of a programmable interval timer. A one-cycle `load` pulse programs it with an initial count and an operating mode. After that the channel advances by one step on every clock cycle in which `tick` is high. The `gate` input either enables counting or starts a new run, depending on the mode. `out` produces the mode's waveform: a terminal flag, a one-shot window, a periodic pulse, a square wave or a strobe. `count` shows the live counter value.

There are six behaviours. Modes 0, 1, 4 and 5 count down once; after zero they wrap to FFFFh and keep running. Modes 2 and 3 reload on every period. An initial count of zero stands for 65536 ticks. Counting is binary only. Every state change is registered on the clock: the effect of a tick, trigger or load appears on the outputs in the following cycle.

Top module: `ivl_timer_chan`

## Requirements
- R1: After reset `count` is 0000h and `out` is low.
- R2: A loaded initial count of 0 behaves as 65536. In mode 0, `out` stays low for 65535 ticks and rises on tick 65536, and `count` reads 0000h right after the load.
- R3: The mode input codes 6 and 7 behave exactly as modes 2 and 3.
- R4: In mode 0, `out` is low after a load and rises on the tick that brings `count` from 1 to 0. It stays high until the next load. A load in mode 0 or 4 restarts the run at once with the new value.
- R5: In modes 0, 1, 4 and 5, `count` goes from 0000h to FFFFh on the next tick and keeps counting. The terminal event is not produced a second time.
- R6: In mode 1, `out` is high until a gate trigger and ticks have no effect before it. After the trigger `out` is low for N ticks and then high.
- R7: In mode 2, `count` reloads N on the tick after it reads 1, and `out` is high for exactly that one tick period. This gives one pulse every N ticks.
- R8: In mode 3, `out` is high for the first (N+1)/2 ticks of each period and low for the rest. `count` falls by two per tick within each half.
- R9: In modes 4 and 5, `out` is a single tick-period strobe when `count` reaches 0. In mode 5, counting waits for a gate trigger after the load.
- R10: A rising `gate` edge restarts modes 1, 2, 3 and 5 from the initial count. In modes 0 and 4 a low `gate` freezes `count` and a rising edge never restarts it.
- R11: A load in the mode already running in modes 1, 2, 3 or 5 does not disturb the current period. The new value is used from the next reload or trigger.
- R12: `count` changes only on a tick, a load or a trigger. When a trigger and a tick fall in the same cycle, the trigger wins and the tick is not counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable, one step per high cycle |
| gate | input | 1 | Gate: enable in modes 0/4, trigger on rising edge otherwise |
| load | input | 1 | One-cycle strobe that captures `load_val` and `mode` |
| load_val | input | W (16) | Initial count, 0 meaning 2^W |
| mode | input | 3 | Operating mode 0..5, codes 6/7 aliasing 2/3 |
| count | output | W (16) | Live counter value |
| out | output | 1 | Channel output waveform |

## Verification
The hardest state to reach is the 65536-tick run after a zero load, because `out` must stay low for the whole run and rise only on the final tick. The bench holds `tick` high for 65535 cycles, checks just before the edge, and then gives the last tick. Two other cases need the gate and the load timed against the count. One is a new value loaded in the middle of a running period. The other is a gate rise that arrives together with a tick. For both, the bench steps the count to a known residue first and then applies the event in a chosen cycle.

// File: rtl/ivl_timer_chan.sv
`timescale 1ns/1ps
module ivl_timer_chan #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         gate,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic [2:0]   mode,
  output logic [W-1:0] count,
  output logic         out
);
  localparam logic [W:0] FULL = {1'b1, {W{1'b0}}};
  localparam logic [W:0] ONE  = {{W{1'b0}}, 1'b1};
  localparam logic [W:0] WRAP = {1'b0, {W{1'b1}}};

  function automatic logic [W:0] span(input logic [W-1:0] v);
    return (v == '0) ? FULL : {1'b0, v};
  endfunction

  function automatic logic [2:0] fold(input logic [2:0] m);
    return (m[2:1] == 2'b11) ? {1'b0, m[1:0]} : m;
  endfunction

  logic [2:0]   mode_q;
  logic [W-1:0] init_q;
  logic [W:0]   per_q, rem_q;
  logic         run_q, hit_q, tc_q, gate_q;

  wire [2:0] mode_n   = fold(mode);
  wire       periodic = (mode_q == 3'd2) || (mode_q == 3'd3);
  wire       gated    = (mode_q == 3'd0) || (mode_q == 3'd4);
  wire       trig     = gate & ~gate_q & ~gated;
  wire       en       = ~gated | gate;
  wire       step     = tick & run_q & en;
  wire       last     = (rem_q == ONE);
  wire       keep     = run_q && (mode_n == mode_q) &&
                        !((mode_n == 3'd0) || (mode_n == 3'd4));
  wire       restart  = load & ~keep;

  wire [W+1:0] dbl     = {rem_q, 1'b0};
  wire         hi_half = dbl > {1'b0, per_q};
  wire [W-1:0] sq      = hi_half ? (dbl[W-1:0] - per_q[W-1:0]) : dbl[W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= 3'd0;
      init_q <= '0;
      per_q  <= FULL;
      rem_q  <= '0;
      run_q  <= 1'b0;
      hit_q  <= 1'b0;
      tc_q   <= 1'b0;
      gate_q <= 1'b0;
    end else begin
      gate_q <= gate;
      if (load) begin
        mode_q <= mode_n;
        init_q <= load_val;
      end
      if (restart) begin
        per_q <= span(load_val);
        rem_q <= span(load_val);
        hit_q <= 1'b0;
        tc_q  <= 1'b0;
        run_q <= !((mode_n == 3'd1) || (mode_n == 3'd5));
      end else if (trig) begin
        per_q <= span(init_q);
        rem_q <= span(init_q);
        hit_q <= 1'b0;
        tc_q  <= 1'b0;
        run_q <= 1'b1;
      end else if (tick) begin
        tc_q <= 1'b0;
        if (step) begin
          if (periodic) begin
            if (last) begin
              rem_q <= span(init_q);
              per_q <= span(init_q);
              tc_q  <= (mode_q == 3'd2);
            end else begin
              rem_q <= rem_q - ONE;
            end
          end else begin
            rem_q <= (rem_q == '0) ? WRAP : rem_q - ONE;
            if (last && !hit_q) begin
              hit_q <= 1'b1;
              tc_q  <= 1'b1;
            end
          end
        end
      end
    end
  end

  always_comb begin
    case (mode_q)
      3'd0:    out = hit_q;
      3'd1:    out = ~run_q | hit_q;
      3'd3:    out = run_q & hi_half;
      default: out = tc_q;
    endcase
  end

  assign count = (mode_q == 3'd3) ? sq : rem_q[W-1:0];

  AST_M0_OUT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 3'd0 && out && !load) |=> out); // R4

  AST_ONESHOT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!periodic && step && rem_q == '0 && !load && !trig) |=> (count == {W{1'b1}})); // R5

  AST_M2_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 3'd2 && tc_q && tick && !last && !load) |=> !out); // R7

  AST_GATE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (gated && !gate && !load) |=> $stable(count)); // R10

  AST_COUNT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load && !trig) |=> $stable(count)); // R12
endmodule

// File: tb/ivl_timer_chan_tb.sv
`timescale 1ns/1ps
module ivl_timer_chan_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        gate = 1'b0;
  logic        load = 1'b0;
  logic [15:0] load_val = '0;
  logic [2:0]  mode = '0;
  logic [15:0] count;
  logic        out;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  ivl_timer_chan #(.W(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .gate(gate), .load(load),
    .load_val(load_val), .mode(mode), .count(count), .out(out)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [15:0] ec, input logic eo);
    n_chk++;
    if (count !== ec || out !== eo) begin
      n_fail++;
      $display("FAIL %s: count=%h out=%b expected count=%h out=%b", req, count, out, ec, eo);
    end
  endtask

  task automatic cyc(input logic tk);
    tick = tk;
    @(posedge clk); #1;
    tick = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(1'b1);
  endtask

  task automatic do_load(input logic [2:0] m, input logic [15:0] v);
    mode = m; load_val = v; load = 1'b1;
    @(posedge clk); #1;
    load = 1'b0;
  endtask

  task automatic set_gate(input logic g);
    gate = g;
    cyc(1'b0);
  endtask

  task automatic test_reset;
    chk("R1 reset", 16'h0000, 1'b0);
  endtask

  task automatic test_mode0;
    set_gate(1'b1);
    do_load(3'd0, 16'd5);
    chk("R4 after load", 16'd5, 1'b0);
    ticks(4);
    chk("R4 before terminal", 16'd1, 1'b0);
    ticks(1);
    chk("R4 terminal", 16'd0, 1'b1);
    ticks(1);
    chk("R5 wrap", 16'hFFFF, 1'b1);
    set_gate(1'b0);
    ticks(3);
    chk("R10 gate low freezes", 16'hFFFF, 1'b1);
    set_gate(1'b1);
    chk("R10 no restart mode0", 16'hFFFF, 1'b1);
    do_load(3'd0, 16'd7);
    chk("R4 reload restarts", 16'd7, 1'b0);
  endtask

  task automatic test_zero;
    do_load(3'd0, 16'd0);
    chk("R2 zero load", 16'h0000, 1'b0);
    tick = 1'b1;
    repeat (65535) @(posedge clk);
    #1 tick = 1'b0;
    chk("R2 one tick left", 16'd1, 1'b0);
    ticks(1);
    chk("R2 full span", 16'd0, 1'b1);
  endtask

  task automatic test_mode1;
    set_gate(1'b0);
    do_load(3'd1, 16'd4);
    chk("R6 idle high", 16'd4, 1'b1);
    ticks(3);
    chk("R6 waits trigger", 16'd4, 1'b1);
    set_gate(1'b1);
    chk("R6 triggered", 16'd4, 1'b0);
    ticks(3);
    chk("R6 window", 16'd1, 1'b0);
    ticks(1);
    chk("R6 end of window", 16'd0, 1'b1);
    ticks(2);
    chk("R5 mode1 wrap", 16'hFFFE, 1'b1);
    set_gate(1'b0);
    set_gate(1'b1);
    chk("R10 retrigger mode1", 16'd4, 1'b0);
  endtask

  task automatic test_mode2;
    do_load(3'd2, 16'd3);
    chk("R7 start", 16'd3, 1'b0);
    ticks(2);
    chk("R7 count 1", 16'd1, 1'b0);
    ticks(1);
    chk("R7 pulse and reload", 16'd3, 1'b1);
    ticks(1);
    chk("R7 pulse one tick", 16'd2, 1'b0);
    do_load(3'd2, 16'd5);
    chk("R11 pending value", 16'd2, 1'b0);
    ticks(2);
    chk("R11 new value at reload", 16'd5, 1'b1);
    ticks(1);
    chk("R11 new period runs", 16'd4, 1'b0);
  endtask

  task automatic test_mode3;
    do_load(3'd3, 16'd5);
    chk("R8 start", 16'd5, 1'b1);
    ticks(1);
    chk("R8 step by two", 16'd3, 1'b1);
    ticks(1);
    chk("R8 third high", 16'd1, 1'b1);
    ticks(1);
    chk("R8 low half", 16'd4, 1'b0);
    ticks(1);
    chk("R8 low half step", 16'd2, 1'b0);
    ticks(1);
    chk("R8 new period", 16'd5, 1'b1);
    ticks(2);
    set_gate(1'b0);
    set_gate(1'b1);
    chk("R10 retrigger mode3", 16'd5, 1'b1);
  endtask

  task automatic test_alias;
    do_load(3'd6, 16'd2);
    chk("R3 code6 start", 16'd2, 1'b0);
    ticks(1);
    chk("R3 code6 count", 16'd1, 1'b0);
    ticks(1);
    chk("R3 code6 pulses", 16'd2, 1'b1);
    do_load(3'd7, 16'd4);
    chk("R3 code7 square", 16'd4, 1'b1);
    ticks(2);
    chk("R3 code7 low half", 16'd4, 1'b0);
  endtask

  task automatic test_mode4;
    do_load(3'd4, 16'd3);
    chk("R9 mode4 start", 16'd3, 1'b0);
    ticks(2);
    chk("R9 mode4 count", 16'd1, 1'b0);
    gate = 1'b0;
    ticks(2);
    chk("R10 mode4 paused", 16'd1, 1'b0);
    gate = 1'b1;
    ticks(1);
    chk("R9 mode4 strobe", 16'd0, 1'b1);
    ticks(1);
    chk("R9 strobe ends", 16'hFFFF, 1'b0);
  endtask

  task automatic test_mode5;
    set_gate(1'b0);
    do_load(3'd5, 16'd2);
    chk("R9 mode5 idle", 16'd2, 1'b0);
    ticks(1);
    chk("R9 mode5 waits", 16'd2, 1'b0);
    gate = 1'b1;
    cyc(1'b1);
    chk("R12 trigger beats tick", 16'd2, 1'b0);
    ticks(1);
    chk("R9 mode5 count", 16'd1, 1'b0);
    ticks(1);
    chk("R9 mode5 strobe", 16'd0, 1'b1);
    ticks(1);
    chk("R5 mode5 wrap", 16'hFFFF, 1'b0);
    cyc(1'b0);
    chk("R12 idle no change", 16'hFFFF, 1'b0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    test_reset();
    test_mode0();
    test_zero();
    test_mode1();
    test_mode2();
    test_mode3();
    test_alias();
    test_mode4();
    test_mode5();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #950000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule